// File: doc/BRIEF.md
# Transparent Clock Residence Time Corrector

This block sits in the forwarding path of a switch that behaves as an end-to-end transparent clock. For every precision-time message leaving the switch it receives the message type, the ingress and egress timestamps taken by the switch's timestamping units, and the correction value carried in the message. It then returns the correction value the message must leave with. A boundary clock would end synchronization at the switch. This block instead lets messages pass through and adds only the time each event message spent inside the switch.

The two event messages are Sync and Delay_Req. Each has its residence time (egress minus ingress, in nanoseconds) converted to the correction format and added to its correction. The correction format is a signed 64-bit count of nanoseconds scaled by 2^16. General messages such as Follow_Up and Delay_Resp, and any unknown type, leave with their correction untouched. If an event message has an egress timestamp earlier than its ingress timestamp, an error flag is raised and the correction passes unchanged. The datapath is a two-stage pipeline that accepts one message per clock.

Top module: `tc_residence_corrector`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_updated and out_neg_err are 0 and out_corr is 0.
- R2: A message of type code 0 (Sync) with egress >= ingress leaves with out_corr = in_corr + (egress - ingress) * 2^16 and out_updated = 1.
- R3: A message of type code 1 (Delay_Req) with egress >= ingress is corrected in the same way as R2, with out_updated = 1.
- R4: Type codes 8 (Follow_Up) and 9 (Delay_Resp) leave with out_corr equal to in_corr, out_updated = 0 and out_neg_err = 0, whatever their timestamps are.
- R5: Any type code other than 0, 1, 8 or 9 leaves with its correction unchanged, out_updated = 0 and out_neg_err = 0.
- R6: An event message (code 0 or 1) whose egress timestamp is below its ingress timestamp leaves with out_neg_err = 1, out_updated = 0 and out_corr equal to in_corr.
- R7: An event message with equal timestamps leaves with its correction unchanged, out_updated = 1 and out_neg_err = 0.
- R8: Each accepted message (in_valid = 1 at a rising edge) produces exactly one out_valid pulse two rising edges later. Messages may arrive on back-to-back cycles, and out_valid is 0 in every other cycle.
- R9: The correction sum is signed two's-complement arithmetic modulo 2^64, so negative incoming corrections are handled and a sum past the positive limit wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A message is presented this cycle |
| in_msg_type | input | 4 | Message type code |
| in_ingress_ts | input | 48 | Ingress timestamp, ns |
| in_egress_ts | input | 48 | Egress timestamp, ns |
| in_corr | input | 64 | Incoming correction, signed ns * 2^16 |
| out_valid | output | 1 | Result for one message |
| out_corr | output | 64 | Outgoing correction |
| out_updated | output | 1 | Residence time was added |
| out_neg_err | output | 1 | Event message with negative residence time |

## Verification
Every result is due two rising edges after the edge that accepts its message: one register holds the residence time and classification, and the second holds the corrected value and flags. The bench presents each message on a falling edge and compares all outputs on the falling edge that follows the second rising edge. It also streams two messages on consecutive cycles, checks each result in its own cycle, and confirms that out_valid falls in the cycle after the last result.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int CORR_W    = 64;
  localparam int FRAC_BITS = 16;
  localparam int TYPE_W    = 4;

  typedef enum logic [TYPE_W-1:0] {
    MSG_SYNC      = 4'd0,
    MSG_DELAY_REQ = 4'd1,
    MSG_FOLLOW_UP = 4'd8,
    MSG_DELAY_RSP = 4'd9
  } msg_code_e;

  // True for message types whose correction receives the residence time.
  function automatic logic is_event_code(input logic [TYPE_W-1:0] code);
    return (code == MSG_SYNC) || (code == MSG_DELAY_REQ);
  endfunction

  // Nanoseconds (already zero-extended) to scaled correction units.
  function automatic logic [CORR_W-1:0] ns_to_corr(input logic [CORR_W-1:0] ns);
    return ns << FRAC_BITS;
  endfunction

endpackage

// File: rtl/tc_msg_classifier.sv
module tc_msg_classifier
  import tc_pkg::*;
(
  input  logic [TYPE_W-1:0] msg_type,
  output logic              is_event
);
  always_comb is_event = is_event_code(msg_type);
endmodule

// File: rtl/tc_residence_stage.sv
module tc_residence_stage
  import tc_pkg::*;
#(
  parameter int TS_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_is_event,
  input  logic [TS_W-1:0]   in_ingress_ts,
  input  logic [TS_W-1:0]   in_egress_ts,
  input  logic [CORR_W-1:0] in_corr,
  output logic              s1_valid,
  output logic              s1_is_event,
  output logic              s1_neg,
  output logic [TS_W-1:0]   s1_res_ns,
  output logic [CORR_W-1:0] s1_corr
);
  localparam int DIFF_W = TS_W + 1;

  logic [DIFF_W-1:0] diff;
  always_comb diff = {1'b0, in_egress_ts} - {1'b0, in_ingress_ts};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_is_event <= 1'b0;
      s1_neg      <= 1'b0;
      s1_res_ns   <= '0;
      s1_corr     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_is_event <= in_is_event;
        s1_neg      <= diff[DIFF_W-1];
        s1_res_ns   <= diff[TS_W-1:0];
        s1_corr     <= in_corr;
      end
    end
  end
endmodule

// File: rtl/tc_corr_update.sv
module tc_corr_update
  import tc_pkg::*;
#(
  parameter int TS_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_is_event,
  input  logic              s1_neg,
  input  logic [TS_W-1:0]   s1_res_ns,
  input  logic [CORR_W-1:0] s1_corr,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_updated,
  output logic              out_neg_err
);
  localparam int PAD_W = CORR_W - TS_W;

  logic              apply;
  logic [CORR_W-1:0] res_scaled;
  logic [CORR_W-1:0] sum;

  always_comb begin
    apply      = s1_is_event && !s1_neg;
    res_scaled = ns_to_corr({{PAD_W{1'b0}}, s1_res_ns});
    sum        = s1_corr + res_scaled;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_corr    <= '0;
      out_updated <= 1'b0;
      out_neg_err <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_corr    <= apply ? sum : s1_corr;
        out_updated <= apply;
        out_neg_err <= s1_is_event && s1_neg;
      end else begin
        out_updated <= 1'b0;
        out_neg_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tc_residence_corrector.sv
module tc_residence_corrector
  import tc_pkg::*;
#(
  parameter int TS_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_msg_type,
  input  logic [TS_W-1:0]   in_ingress_ts,
  input  logic [TS_W-1:0]   in_egress_ts,
  input  logic [63:0]       in_corr,
  output logic              out_valid,
  output logic [63:0]       out_corr,
  output logic              out_updated,
  output logic              out_neg_err
);
  logic              in_is_event;
  logic              s1_valid;
  logic              s1_is_event;
  logic              s1_neg;
  logic [TS_W-1:0]   s1_res_ns;
  logic [CORR_W-1:0] s1_corr;

  tc_msg_classifier u_class (
    .msg_type (in_msg_type),
    .is_event (in_is_event)
  );

  tc_residence_stage #(.TS_W(TS_W)) u_stage (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_is_event   (in_is_event),
    .in_ingress_ts (in_ingress_ts),
    .in_egress_ts  (in_egress_ts),
    .in_corr       (in_corr),
    .s1_valid      (s1_valid),
    .s1_is_event   (s1_is_event),
    .s1_neg        (s1_neg),
    .s1_res_ns     (s1_res_ns),
    .s1_corr       (s1_corr)
  );

  tc_corr_update #(.TS_W(TS_W)) u_update (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_valid    (s1_valid),
    .s1_is_event (s1_is_event),
    .s1_neg      (s1_neg),
    .s1_res_ns   (s1_res_ns),
    .s1_corr     (s1_corr),
    .out_valid   (out_valid),
    .out_corr    (out_corr),
    .out_updated (out_updated),
    .out_neg_err (out_neg_err)
  );
endmodule

// File: rtl/tc_residence_corrector_chk.sv
module tc_residence_corrector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        s1_valid,
  input logic        s1_is_event,
  input logic        s1_neg,
  input logic [63:0] s1_corr,
  input logic        out_valid,
  input logic [63:0] out_corr,
  input logic        out_updated,
  input logic        out_neg_err
);
  // R8: accepted message reaches the middle stage one edge later
  p_stage_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  // R8: middle stage result appears at the output one edge later
  p_out_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);

  // R8: no output pulse without a message in the middle stage
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R6: error and update never raised together
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_neg_err |-> !out_updated);

  // R6: error only for an event message that had a negative residence
  p_err_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (out_neg_err == $past(s1_is_event && s1_neg)));

  // R4, R5: a message not updated keeps its incoming correction
  p_pass_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_is_event |=> (out_corr == $past(s1_corr)) && !out_updated);

  // R2: a valid event message with non-negative residence is updated
  p_event_upd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_is_event && !s1_neg |=> out_updated);

  // R1: flags are quiet whenever no result is presented
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_updated && !out_neg_err);
endmodule

bind tc_residence_corrector tc_residence_corrector_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .s1_valid    (s1_valid),
  .s1_is_event (s1_is_event),
  .s1_neg      (s1_neg),
  .s1_corr     (s1_corr),
  .out_valid   (out_valid),
  .out_corr    (out_corr),
  .out_updated (out_updated),
  .out_neg_err (out_neg_err)
);

// File: tb/tc_residence_corrector_tb.sv
module tc_residence_corrector_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_msg_type = '0;
  logic [47:0] in_ingress_ts = '0;
  logic [47:0] in_egress_ts = '0;
  logic [63:0] in_corr = '0;
  logic        out_valid;
  logic [63:0] out_corr;
  logic        out_updated;
  logic        out_neg_err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tc_residence_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg_type(in_msg_type),
    .in_ingress_ts(in_ingress_ts), .in_egress_ts(in_egress_ts), .in_corr(in_corr),
    .out_valid(out_valid), .out_corr(out_corr), .out_updated(out_updated),
    .out_neg_err(out_neg_err)
  );

  typedef struct packed {
    logic [3:0]  typ;
    logic [47:0] ing;
    logic [47:0] egr;
    logic [63:0] corr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  48'd1000,        48'd1750,        64'd0},
    '{4'd1,  48'd5000,        48'd5123,        64'h0000_0000_0012_3456},
    '{4'd0,  48'h0FFF_0000_0000, 48'h0FFF_0001_0000, 64'h0000_0100_0000_0000},
    '{4'd8,  48'd10,          48'd99999,       64'h0000_0000_ABCD_0000},
    '{4'd9,  48'd400,         48'd900,         64'h0000_0005_0000_0001},
    '{4'd8,  48'd900,         48'd400,         64'd77},
    '{4'd5,  48'd1,           48'd100,         64'd42},
    '{4'd15, 48'd0,           48'd5,           64'hFFFF_FFFF_FFFF_FFFF},
    '{4'd0,  48'd2000,        48'd1999,        64'd300},
    '{4'd1,  48'd7,           48'd3,           64'd9}
  };

  // Expected correction restated from the requirements.
  function automatic logic [63:0] exp_corr(input logic [3:0] t, input logic [47:0] i,
                                           input logic [47:0] e, input logic [63:0] c);
    if ((t == 4'd0 || t == 4'd1) && e >= i)
      return c + ((64'(e) - 64'(i)) * 64'd65536);
    return c;
  endfunction

  function automatic string req_of(input logic [3:0] t, input logic [47:0] i,
                                   input logic [47:0] e);
    if ((t == 4'd0 || t == 4'd1) && e < i) return "R6";
    if (t == 4'd0) return "R2";
    if (t == 4'd1) return "R3";
    if (t == 4'd8 || t == 4'd9) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] t, input logic [47:0] i,
                       input logic [47:0] e, input logic [63:0] c);
    in_valid = 1'b1; in_msg_type = t; in_ingress_ts = i; in_egress_ts = e; in_corr = c;
  endtask

  task automatic check_result(input string tag, input logic [3:0] t, input logic [47:0] i,
                              input logic [47:0] e, input logic [63:0] c);
    logic ev;
    ev = (t == 4'd0 || t == 4'd1);
    chk({tag, " valid"},   64'(out_valid), 64'd1);
    chk({tag, " corr"},    out_corr, exp_corr(t, i, e, c));
    chk({tag, " updated"}, 64'(out_updated), 64'(ev && e >= i));
    chk({tag, " neg_err"}, 64'(out_neg_err), 64'(ev && e < i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 corr in reset", out_corr, 64'd0);
    chk("R1 flags in reset", 64'({out_updated, out_neg_err}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    chk("R1 corr after reset", out_corr, 64'd0);

    // Table walk: one message, result due two edges later
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].typ, VECS[k].ing, VECS[k].egr, VECS[k].corr);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check_result(req_of(VECS[k].typ, VECS[k].ing, VECS[k].egr),
                   VECS[k].typ, VECS[k].ing, VECS[k].egr, VECS[k].corr);
      @(negedge clk);
      chk("R8 idle after pulse", 64'(out_valid), 64'd0);
    end

    // R7: equal timestamps
    drive(4'd0, 48'd12345, 48'd12345, 64'd555);
    @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check_result("R7", 4'd0, 48'd12345, 48'd12345, 64'd555);

    // R9: negative incoming correction, and wrap past positive limit
    drive(4'd1, 48'd100, 48'd103, 64'hFFFF_FFFF_FFFF_0000);
    @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check_result("R9 negative in", 4'd1, 48'd100, 48'd103, 64'hFFFF_FFFF_FFFF_0000);
    chk("R9 negative sum", out_corr, 64'h0000_0000_0002_0000);
    drive(4'd0, 48'd0, 48'd1, 64'h7FFF_FFFF_FFFF_0000);
    @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R9 wrap", out_corr, 64'h8000_0000_0000_0000);

    // R8: back-to-back messages
    drive(4'd0, 48'd10, 48'd20, 64'd1);
    @(negedge clk);
    drive(4'd9, 48'd30, 48'd40, 64'd2);
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R8 first", 4'd0, 48'd10, 48'd20, 64'd1);
    @(negedge clk);
    check_result("R8 second", 4'd9, 48'd30, 48'd40, 64'd2);
    @(negedge clk);
    chk("R8 idle after burst", 64'(out_valid), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule